// File: doc/BRIEF.md
# CEC Transmit Request Controller

This block owns the three-bit control word of a consumer-electronics-control bus interface and turns software transmit requests into timed commands for a separate bit-level transmitter. Software writes and reads the word through a simple strobe port. The word holds an enable bit, a begin-transmission request and a final-byte marker. The transmitter sends back its outcome as single-cycle events: positive completion, underrun, negative acknowledge, transmit error and lost arbitration.

Before a request reaches the transmitter, the controller waits for any reception in progress to end. It then counts a parameterised number of quiet bit periods, called the signal-free time, on a tick input. If the bus shows activity during that count, the count starts again. The controller then issues a one-cycle start command. A lost arbitration keeps the request alive and starts the whole wait again. Every other outcome retires the request. Turning the enable bit off wipes the control word and produces a one-cycle abort pulse.

The transmitter also receives the final-byte marker as a level. It receives a ping flag as well, which marks a request made while the final-byte marker was already set, so the message is a lone header byte.

Top module: `cec_txreq_ctrl`

## Requirements
- R1: After reset the control word reads 0. Its fields are at fixed positions: enable at bit 0, begin request at bit 1, final-byte marker at bit 2.
- R2: A write with bit 0 equal to 0 clears all three bits at the next edge. `tx_abort` is high for exactly the one cycle after enable falls.
- R3: A write that sets bit 1 or bit 2 only takes effect if enable was already 1 before that write. From the disabled state, writing 3'b111 leaves only enable set.
- R4: While enable stays 1, writing 0 to bit 1 or bit 2 leaves that bit unchanged.
- R5: Any of completion, underrun, negative acknowledge or transmit error clears bits 1 and 2. In a cycle that has both such an event and a software set, the clear wins.
- R6: Lost arbitration leaves bit 1 set. The request goes through the full signal-free wait again and produces another start command.
- R7: No start command is issued while `rx_busy` is high, or in the cycle after it was high. A request made during reception waits for it to end.
- R8: `tx_start` is a one-cycle pulse. It follows SFT_BITS counted `bit_tick` cycles without `bus_active`. A cycle with `bus_active` high restarts the count.
- R9: `tx_ping` goes high when bit 1 is set while bit 2 was already 1. It falls when the request is retired.
- R10: Bit 1 reads back 1 from the request until the request is retired, including while waiting and while transmitting.
- R11: `tx_last` follows bit 2 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 3 | Write data {final, begin, enable} |
| reg_rdata | output | 3 | Current control word |
| ev_done_ack | input | 1 | Message finished with positive acknowledge |
| ev_underrun | input | 1 | Transmit data underrun |
| ev_nack | input | 1 | Negative acknowledge received |
| ev_txerr | input | 1 | Transmit error |
| ev_arb_lost | input | 1 | Arbitration lost |
| rx_busy | input | 1 | Reception in progress |
| bus_active | input | 1 | Bus seen active in this cycle |
| bit_tick | input | 1 | One pulse per nominal bit period |
| tx_start | output | 1 | Start command to the transmitter |
| tx_last | output | 1 | Current byte is the final one |
| tx_ping | output | 1 | Message is a single header byte |
| tx_abort | output | 1 | Abort pulse on disable |

## Verification
The hardest case to reach is lost arbitration followed by a retry that is itself delayed: by bus activity part way through the second quiet count, and by a reception that starts before the retried start command. The stimulus holds a request open and injects the arbitration event in the cycle after the first start command. It then raises `bus_active` and later `rx_busy` while the tick generator is running. The model tracks each restart of the count, so the cycle of the second start command is checked exactly.

// File: rtl/cec_txreq_pkg.sv
package cec_txreq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_WAIT_RX = 2'd1,
      SEQ_QUIET   = 2'd2,
      SEQ_ACTIVE  = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic fin;   // bit 2: final byte marker
      logic req;   // bit 1: begin transmission request
      logic en;    // bit 0: enable
   } ctrl_word_t;

   localparam int CTRL_W = 3;

endpackage

// File: rtl/cec_ctrl_word.sv
module cec_ctrl_word
   import cec_txreq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              hw_retire,
   output ctrl_word_t        word,
   output logic              ping
);

   ctrl_word_t word_q;
   ctrl_word_t word_n;
   logic       ping_q;
   logic       ping_n;
   logic       kill;

   assign kill = wr & ~wdata[0];

   always_comb begin
      word_n = word_q;
      ping_n = ping_q;
      if (kill) begin
         word_n = '0;
         ping_n = 1'b0;
      end else begin
         if (wr) begin
            word_n.en = 1'b1;
         end
         if (wr && word_q.en) begin
            word_n.req = word_q.req | wdata[1];
            word_n.fin = word_q.fin | wdata[2];
         end
         if (hw_retire) begin
            word_n.req = 1'b0;
            word_n.fin = 1'b0;
         end
         if (!word_q.req && word_n.req) begin
            ping_n = word_q.fin;
         end else if (!word_n.req) begin
            ping_n = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         ping_q <= 1'b0;
      end else begin
         word_q <= word_n;
         ping_q <= ping_n;
      end
   end

   assign word = word_q;
   assign ping = ping_q;

endmodule

// File: rtl/cec_quiet_timer.sv
module cec_quiet_timer #(
   parameter int SFT_BITS = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic busy_line,
   output logic done
);

   generate
      if (SFT_BITS == 1) begin : g_single
         assign done = run & tick & ~busy_line;
      end else begin : g_count
         localparam int CNT_W = $clog2(SFT_BITS);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(SFT_BITS - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || busy_line) begin
               cnt_q <= '0;
            end else if (tick) begin
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
         end

         assign done = run & tick & ~busy_line & (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/cec_tx_sequencer.sv
module cec_tx_sequencer
   import cec_txreq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       rx_busy,
   input  logic       quiet_done,
   input  logic       arb_lost,
   input  logic       hw_retire,
   output logic       quiet_run,
   output logic       start
);

   seq_state_t st_q;
   seq_state_t st_n;
   logic       start_n;
   logic       start_q;

   always_comb begin
      st_n    = st_q;
      start_n = 1'b0;
      if (!req) begin
         st_n = SEQ_IDLE;
      end else begin
         unique case (st_q)
            SEQ_IDLE:    st_n = rx_busy ? SEQ_WAIT_RX : SEQ_QUIET;
            SEQ_WAIT_RX: if (!rx_busy) st_n = SEQ_QUIET;
            SEQ_QUIET: begin
               if (rx_busy) begin
                  st_n = SEQ_WAIT_RX;
               end else if (quiet_done) begin
                  st_n    = SEQ_ACTIVE;
                  start_n = 1'b1;
               end
            end
            SEQ_ACTIVE: begin
               if (arb_lost)       st_n = SEQ_QUIET;
               else if (hw_retire) st_n = SEQ_IDLE;
            end
            default:     st_n = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         start_q <= 1'b0;
      end else begin
         st_q    <= st_n;
         start_q <= start_n;
      end
   end

   assign quiet_run = (st_q == SEQ_QUIET);
   assign start     = start_q;

endmodule

// File: rtl/cec_txreq_ctrl.sv
module cec_txreq_ctrl
   import cec_txreq_pkg::*;
#(
   parameter int SFT_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic              ev_done_ack,
   input  logic              ev_underrun,
   input  logic              ev_nack,
   input  logic              ev_txerr,
   input  logic              ev_arb_lost,
   input  logic              rx_busy,
   input  logic              bus_active,
   input  logic              bit_tick,
   output logic              tx_start,
   output logic              tx_last,
   output logic              tx_ping,
   output logic              tx_abort
);

   if (SFT_BITS < 1) begin : g_bad_sft
      $error("SFT_BITS must be at least 1");
   end

   ctrl_word_t word;
   logic       ping;
   logic       retire;
   logic       quiet_run;
   logic       quiet_done;
   logic       en_d_q;

   assign retire = ev_done_ack | ev_underrun | ev_nack | ev_txerr;

   cec_ctrl_word u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .wdata     (reg_wdata),
      .hw_retire (retire),
      .word      (word),
      .ping      (ping)
   );

   cec_quiet_timer #(.SFT_BITS(SFT_BITS)) u_quiet (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (quiet_run),
      .tick      (bit_tick),
      .busy_line (bus_active),
      .done      (quiet_done)
   );

   cec_tx_sequencer u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (word.req),
      .rx_busy    (rx_busy),
      .quiet_done (quiet_done),
      .arb_lost   (ev_arb_lost),
      .hw_retire  (retire),
      .quiet_run  (quiet_run),
      .start      (tx_start)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) en_d_q <= 1'b0;
      else        en_d_q <= word.en;
   end

   assign reg_rdata = word;
   assign tx_last   = word.fin;
   assign tx_ping   = ping;
   assign tx_abort  = en_d_q & ~word.en;

endmodule

// File: rtl/cec_txreq_ctrl_chk.sv
module cec_txreq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic [2:0] reg_wdata,
   input logic [2:0] reg_rdata,
   input logic       ev_done_ack,
   input logic       ev_underrun,
   input logic       ev_nack,
   input logic       ev_txerr,
   input logic       ev_arb_lost,
   input logic       rx_busy,
   input logic       tx_start,
   input logic       tx_last,
   input logic       tx_ping,
   input logic       tx_abort
);

   logic any_retire;
   assign any_retire = ev_done_ack | ev_underrun | ev_nack | ev_txerr;

   AST_DISABLE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_wdata[0]) |=> (reg_rdata == 3'b000)); // R2

   AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |=> !tx_abort); // R2

   AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rdata[0] && !reg_rdata[1]) |=> !reg_rdata[1]); // R3

   AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      any_retire |=> (!reg_rdata[1] && !reg_rdata[2])); // R5

   AST_ARB_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_arb_lost && reg_rdata[1] && !any_retire && !(reg_wr && !reg_wdata[0]))
      |=> reg_rdata[1]); // R6

   AST_NO_START_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy |=> !tx_start); // R7

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start); // R8

   AST_PING_HAS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ping |-> tx_last); // R9

   AST_LAST_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last == reg_rdata[2]); // R11

endmodule

bind cec_txreq_ctrl cec_txreq_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .ev_done_ack (ev_done_ack),
   .ev_underrun (ev_underrun),
   .ev_nack     (ev_nack),
   .ev_txerr    (ev_txerr),
   .ev_arb_lost (ev_arb_lost),
   .rx_busy     (rx_busy),
   .tx_start    (tx_start),
   .tx_last     (tx_last),
   .tx_ping     (tx_ping),
   .tx_abort    (tx_abort)
);

// File: tb/cec_txreq_ctrl_test.sv
module cec_txreq_ctrl_test;

   localparam int SFT = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_wdata = 3'b000;
   logic [2:0] reg_rdata;
   logic       ev_done_ack = 1'b0, ev_underrun = 1'b0, ev_nack = 1'b0;
   logic       ev_txerr = 1'b0, ev_arb_lost = 1'b0;
   logic       rx_busy = 1'b0, bus_active = 1'b0, bit_tick = 1'b0;
   logic       tx_start, tx_last, tx_ping, tx_abort;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int starts = 0;
   logic tick_on = 1'b0;
   string phase_tag = "R1";

   always #4 clk = ~clk;

   cec_txreq_ctrl #(.SFT_BITS(SFT)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ev_done_ack(ev_done_ack), .ev_underrun(ev_underrun),
      .ev_nack(ev_nack), .ev_txerr(ev_txerr), .ev_arb_lost(ev_arb_lost),
      .rx_busy(rx_busy), .bus_active(bus_active), .bit_tick(bit_tick),
      .tx_start(tx_start), .tx_last(tx_last), .tx_ping(tx_ping), .tx_abort(tx_abort)
   );

   // Behavioural reference: integers for state, phase 0 idle, 1 wait rx,
   // 2 quiet count, 3 transmitting.
   int m_en = 0, m_req = 0, m_fin = 0, m_ping = 0;
   int m_phase = 0, m_quiet = 0, m_start = 0, m_en_prev = 0;

   always @(posedge clk) begin
      int en, req, fin, png, ph, q, st, retire, quiet_hit;
      if (!rst_n) begin
         m_en = 0; m_req = 0; m_fin = 0; m_ping = 0;
         m_phase = 0; m_quiet = 0; m_start = 0; m_en_prev = 0;
      end else begin
         retire = (ev_done_ack || ev_underrun || ev_nack || ev_txerr) ? 1 : 0;
         quiet_hit = (m_phase == 2 && bit_tick && !bus_active && m_quiet == SFT - 1) ? 1 : 0;
         q = (m_phase != 2 || bus_active) ? 0 : (bit_tick ? (quiet_hit ? 0 : m_quiet + 1) : m_quiet);
         en = m_en; req = m_req; fin = m_fin; png = m_ping;
         if (reg_wr && !reg_wdata[0]) begin
            en = 0; req = 0; fin = 0; png = 0;
         end else begin
            if (reg_wr) en = 1;
            if (reg_wr && m_en == 1) begin
               if (reg_wdata[1]) req = 1;
               if (reg_wdata[2]) fin = 1;
            end
            if (retire) begin req = 0; fin = 0; end
            if (m_req == 0 && req == 1) png = m_fin;
            else if (req == 0) png = 0;
         end
         ph = m_phase; st = 0;
         if (m_req == 0) ph = 0;
         else if (m_phase == 0) ph = rx_busy ? 1 : 2;
         else if (m_phase == 1) begin if (!rx_busy) ph = 2; end
         else if (m_phase == 2) begin
            if (rx_busy) ph = 1;
            else if (quiet_hit) begin ph = 3; st = 1; end
         end else begin
            if (ev_arb_lost) ph = 2;
            else if (retire) ph = 0;
         end
         m_en_prev = m_en;
         m_en = en; m_req = req; m_fin = fin; m_ping = png;
         m_phase = ph; m_quiet = q; m_start = st;
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   // Every-clock comparison against the model.
   always @(negedge clk) begin
      cyc++;
      if (tx_start) starts++;
      if (rst_n) begin
         check(phase_tag, "rdata", int'(reg_rdata), m_fin*4 + m_req*2 + m_en);
         check("R8", "tx_start", int'(tx_start), m_start);
         check("R11", "tx_last", int'(tx_last), m_fin);
         check("R9", "tx_ping", int'(tx_ping), m_ping);
         check("R2", "tx_abort", int'(tx_abort), (m_en_prev == 1 && m_en == 0) ? 1 : 0);
      end
      if (cyc > 20000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   always @(negedge clk) bit_tick <= tick_on && cyc[0];

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = 3'b000;
   endtask

   task automatic wait_start(input int limit);
      int s0;
      s0 = starts;
      for (int i = 0; i < limit && starts == s0; i++) @(negedge clk);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      check("R1", "reset word", int'(reg_rdata), 0);
      check("R1", "reset abort", int'(tx_abort), 0);

      phase_tag = "R3";
      wr(3'b111);
      check("R3", "set from disabled", int'(reg_rdata), 1);

      phase_tag = "R10";
      tick_on = 1'b1;
      wr(3'b011);
      check("R10", "busy readback", int'(reg_rdata[1]), 1);
      step(2);
      @(negedge clk) bus_active = 1'b1;
      @(negedge clk) bus_active = 1'b0;
      wait_start(60);
      check("R8", "first start seen", starts, 1);
      check("R10", "busy while active", int'(reg_rdata[1]), 1);

      phase_tag = "R6";
      @(negedge clk) ev_arb_lost = 1'b1;
      @(negedge clk) ev_arb_lost = 1'b0;
      check("R6", "request kept", int'(reg_rdata[1]), 1);
      step(2);
      @(negedge clk) bus_active = 1'b1;
      @(negedge clk) bus_active = 1'b0;
      @(negedge clk) rx_busy = 1'b1;
      step(6);
      check("R7", "no retry during rx", starts, 1);
      @(negedge clk) rx_busy = 1'b0;
      wait_start(60);
      check("R6", "retry start", starts, 2);

      phase_tag = "R4";
      wr(3'b001);
      check("R4", "zero write keeps req", int'(reg_rdata), 3);

      phase_tag = "R5";
      @(negedge clk) ev_done_ack = 1'b1;
      @(negedge clk) ev_done_ack = 1'b0;
      check("R5", "done retires", int'(reg_rdata), 1);

      @(negedge clk) begin rx_busy = 1'b1; reg_wr = 1'b1; reg_wdata = 3'b011; ev_txerr = 1'b1; end
      @(negedge clk) begin reg_wr = 1'b0; ev_txerr = 1'b0; end
      check("R5", "clear beats set", int'(reg_rdata), 1);

      phase_tag = "R7";
      wr(3'b011);
      step(12);
      check("R7", "held during rx", starts, 2);
      check("R10", "pending readback", int'(reg_rdata[1]), 1);
      @(negedge clk) rx_busy = 1'b0;
      wait_start(60);
      check("R7", "start after rx", starts, 3);
      @(negedge clk) ev_underrun = 1'b1;
      @(negedge clk) ev_underrun = 1'b0;
      check("R5", "underrun retires", int'(reg_rdata), 1);

      phase_tag = "R9";
      wr(3'b101);
      check("R11", "final marker", int'(tx_last), 1);
      wr(3'b011);
      check("R9", "ping flagged", int'(tx_ping), 1);
      wait_start(60);
      @(negedge clk) ev_nack = 1'b1;
      @(negedge clk) ev_nack = 1'b0;
      check("R9", "ping dropped", int'(tx_ping), 0);
      check("R5", "nack retires", int'(reg_rdata), 1);

      phase_tag = "R2";
      wr(3'b111);
      step(1);
      @(negedge clk) begin reg_wr = 1'b1; reg_wdata = 3'b000; end
      @(negedge clk) reg_wr = 1'b0;
      check("R2", "wiped", int'(reg_rdata), 0);
      check("R2", "abort pulse", int'(tx_abort), 1);
      step(1);
      check("R2", "abort gone", int'(tx_abort), 0);
      step(4);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule